// File: doc/BRIEF.md
# Calendar Shadow Register Synchronizer

This block sits between a real-time clock core and the bus that software uses to read it. The calendar counters run on a slow clock of their own, so a bus read that samples them directly can catch the subseconds, time and date fields in the middle of an update and return a mix of old and new values. To prevent that, the block keeps bus-domain shadow copies of the three calendar words. Every two RTC clock periods it latches the live values on the RTC side and hands them over with a single toggle. That toggle is synchronized into the bus domain, where all three shadows load together and a "synchronized" flag is raised.

While the device sits in a low-power stop or standby state, no copies are launched. Once that state ends, a fresh copy is in the shadows within a bounded number of RTC periods. Software can clear the flag and then wait for it to be set again, which guarantees that it reads values taken after the clear. When software does not want to wait, it can set a bypass control: reads then return the live values through a plain two-flop synchronizer, and the flag is left alone.

The bus clock is assumed to run at least four times faster than the RTC clock, so that each launched copy is captured before the RTC side overwrites its holding register.

Top module: `cal_shadow_sync`

## Requirements
- R1: While reset is held, and before the first copy after it, `rd_ssr`, `rd_tr` and `rd_dr` read 0 (bypass off) and `sync_flag` reads 0.
- R2: While `lp_active` is low, a copy is launched once every 2 RTC clock periods. With bypass off, a live value held steady for 3 RTC periods plus 6 bus cycles appears on the read outputs.
- R3: The three shadows load in the same bus cycle from a single RTC-side snapshot, so the read outputs never show fields taken from two different live snapshots.
- R4: Each completed copy sets `sync_flag` to 1 when `bypass_en` is 0.
- R5: A bus cycle with `flag_wr`=1 and `flag_wdata`=0 clears `sync_flag`. `flag_wdata`=1 has no effect. When a clear and a flag-setting copy fall in the same cycle, the copy wins.
- R6: While `lp_active` is 1, no copy is launched: the shadows keep their values and `sync_flag` is not set, even if the live values change.
- R7: Once `lp_active` falls, a copy of the current live values reaches the shadows within 4 RTC clock periods plus the bus-side synchronizer latency of at most 4 bus cycles, and `sync_flag` is set.
- R8: With `bypass_en`=1, the read outputs show the live values through a two-stage bus-clock synchronizer (no more than 3 bus cycles after a change), and `sync_flag` is never set. Shadows keep updating underneath and are shown again once bypass ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rtc_clk | input | 1 | RTC domain clock |
| rtc_rst_n | input | 1 | RTC domain synchronous active-low reset |
| live_ssr | input | SS_W | Live subseconds value (RTC domain) |
| live_tr | input | TM_W | Live time value (RTC domain) |
| live_dr | input | DT_W | Live date value (RTC domain) |
| lp_active | input | 1 | Low-power stop/standby indicator (RTC domain), 1 = suppress copies |
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus domain synchronous active-low reset |
| bypass_en | input | 1 | 1 = reads return synchronized live values |
| flag_wr | input | 1 | Write strobe for the synchronized flag |
| flag_wdata | input | 1 | Write data for the flag, 0 clears it, 1 is ignored |
| rd_ssr | output | SS_W | Subseconds read value |
| rd_tr | output | TM_W | Time read value |
| rd_dr | output | DT_W | Date read value |
| sync_flag | output | 1 | Set by each completed copy, cleared by software |

## Verification
Every live value the bench drives ties the three fields to a single seed. A monitor checks on every bus cycle that the three read outputs still agree on one seed, so a design that loaded the shadows at different times, or from a holding register that moved while being captured, would show torn values. The bench clears the flag and then changes the live values during low power, to catch a design that copies or sets the flag during stop mode. It then times the refresh after exit against the four-period bound, which a design that waited for a full free-running period or left a copy pending would miss. In bypass it clears the flag while copies continue underneath, which catches a design that still sets the flag or returns stale shadows instead of the live values.

// File: rtl/cal_shadow_pkg.sv
// Package: shared defaults and the flag update rule for the calendar
// shadow synchronizer. Assumes nothing beyond a synthesizable function.
package cal_shadow_pkg;

    localparam int unsigned DEF_SS_W        = 16;
    localparam int unsigned DEF_TM_W        = 24;
    localparam int unsigned DEF_DT_W        = 24;
    localparam int unsigned DEF_COPY_PERIOD = 2;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Next value of the synchronized flag: a set beats a clear in the same cycle.
    function automatic logic flag_next(input logic cur, input logic set, input logic clr);
        logic nxt;
        nxt = cur;
        if (clr) nxt = 1'b0;
        if (set) nxt = 1'b1;
        return nxt;
    endfunction

endpackage

// File: rtl/cal_sync_ff.sv
// Module: multi-stage flip-flop synchronizer for a vector.
// Assumes: each bit is either quasi-static or a toggle; no coherence
// across bits is promised by this module alone. Reset clears every stage.
module cal_sync_ff #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Purpose: first capture stage from the foreign domain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            // Purpose: further stage that lets metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/cal_xfer_launch.sv
// Module: RTC-domain side of the shadow transfer. Counts RTC periods,
// snapshots the live calendar words into a holding register every
// COPY_PERIOD cycles and toggles a request line for the bus side.
// Assumes: the bus side captures a request before the next one is
// launched (bus clock at least four times the RTC clock). While
// lp_active is high nothing is launched and the period counter restarts.
module cal_xfer_launch #(
    parameter int unsigned SS_W        = 16,
    parameter int unsigned TM_W        = 24,
    parameter int unsigned DT_W        = 24,
    parameter int unsigned COPY_PERIOD = 2
) (
    input  logic            rtc_clk,
    input  logic            rtc_rst_n,
    input  logic [SS_W-1:0] live_ssr,
    input  logic [TM_W-1:0] live_tr,
    input  logic [DT_W-1:0] live_dr,
    input  logic            lp_active,
    output logic [SS_W-1:0] hold_ssr,
    output logic [TM_W-1:0] hold_tr,
    output logic [DT_W-1:0] hold_dr,
    output logic            xfer_req
);

    localparam int unsigned CNT_W = (COPY_PERIOD > 1) ? $clog2(COPY_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(COPY_PERIOD - 1);

    logic [CNT_W-1:0] period_cnt_q;
    logic             period_tick;
    logic             launch;

    assign period_tick = (period_cnt_q == CNT_LAST);
    assign launch      = period_tick && !lp_active;

    // Purpose: free-running copy period counter, held at zero in low power.
    always_ff @(posedge rtc_clk) begin
        if (!rtc_rst_n)       period_cnt_q <= '0;
        else if (lp_active)   period_cnt_q <= '0;
        else if (period_tick) period_cnt_q <= '0;
        else                  period_cnt_q <= period_cnt_q + 1'b1;
    end

    // Purpose: snapshot all three live words at once on a launch.
    always_ff @(posedge rtc_clk) begin
        if (!rtc_rst_n) begin
            hold_ssr <= '0;
            hold_tr  <= '0;
            hold_dr  <= '0;
        end else if (launch) begin
            hold_ssr <= live_ssr;
            hold_tr  <= live_tr;
            hold_dr  <= live_dr;
        end
    end

    // Purpose: toggle the request so the bus side sees one edge per copy.
    always_ff @(posedge rtc_clk) begin
        if (!rtc_rst_n)  xfer_req <= 1'b0;
        else if (launch) xfer_req <= ~xfer_req;
    end

endmodule

// File: rtl/cal_xfer_capture.sv
// Module: bus-domain side of the shadow transfer. Synchronizes the
// request toggle, detects its edge, loads all three shadows from the
// (then stable) holding register in one cycle and maintains the
// synchronized flag. Assumes the holding register does not change
// between the request toggle and the capture edge.
module cal_xfer_capture #(
    parameter int unsigned SS_W        = 16,
    parameter int unsigned TM_W        = 24,
    parameter int unsigned DT_W        = 24,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            bus_clk,
    input  logic            bus_rst_n,
    input  logic            xfer_req,
    input  logic [SS_W-1:0] hold_ssr,
    input  logic [TM_W-1:0] hold_tr,
    input  logic [DT_W-1:0] hold_dr,
    input  logic            bypass_en,
    input  logic            flag_wr,
    input  logic            flag_wdata,
    output logic [SS_W-1:0] shd_ssr,
    output logic [TM_W-1:0] shd_tr,
    output logic [DT_W-1:0] shd_dr,
    output logic            sync_flag,
    output logic            cap_pulse
);

    import cal_shadow_pkg::*;

    logic req_sync;
    logic req_seen_q;
    logic flag_set;
    logic flag_clr;

    cal_sync_ff #(
        .W      (1),
        .STAGES (SYNC_STAGES)
    ) u_req_sync (
        .clk   (bus_clk),
        .rst_n (bus_rst_n),
        .d     (xfer_req),
        .q     (req_sync)
    );

    // Purpose: remember the last synchronized request level for edge detect.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) req_seen_q <= 1'b0;
        else            req_seen_q <= req_sync;
    end

    assign cap_pulse = req_sync ^ req_seen_q;
    assign flag_set  = cap_pulse && !bypass_en;
    assign flag_clr  = flag_wr && !flag_wdata;

    // Purpose: load the three shadows together on a detected request edge.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            shd_ssr <= '0;
            shd_tr  <= '0;
            shd_dr  <= '0;
        end else if (cap_pulse) begin
            shd_ssr <= hold_ssr;
            shd_tr  <= hold_tr;
            shd_dr  <= hold_dr;
        end
    end

    // Purpose: synchronized flag, set by a copy outside bypass, cleared by software.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) sync_flag <= 1'b0;
        else            sync_flag <= flag_next(sync_flag, flag_set, flag_clr);
    end

endmodule

// File: rtl/cal_shadow_sync.sv
// Module: calendar shadow register synchronizer (top). Ties the RTC-side
// launcher to the bus-side capture, adds a two-flop path for the live
// values and selects between shadows and live values for reads.
// Assumes: bus_clk is at least four times faster than rtc_clk; each
// domain has its own synchronous active-low reset.
module cal_shadow_sync #(
    parameter int unsigned SS_W        = cal_shadow_pkg::DEF_SS_W,
    parameter int unsigned TM_W        = cal_shadow_pkg::DEF_TM_W,
    parameter int unsigned DT_W        = cal_shadow_pkg::DEF_DT_W,
    parameter int unsigned COPY_PERIOD = cal_shadow_pkg::DEF_COPY_PERIOD,
    parameter int unsigned SYNC_STAGES = cal_shadow_pkg::DEF_SYNC_STAGES
) (
    input  logic            rtc_clk,
    input  logic            rtc_rst_n,
    input  logic [SS_W-1:0] live_ssr,
    input  logic [TM_W-1:0] live_tr,
    input  logic [DT_W-1:0] live_dr,
    input  logic            lp_active,
    input  logic            bus_clk,
    input  logic            bus_rst_n,
    input  logic            bypass_en,
    input  logic            flag_wr,
    input  logic            flag_wdata,
    output logic [SS_W-1:0] rd_ssr,
    output logic [TM_W-1:0] rd_tr,
    output logic [DT_W-1:0] rd_dr,
    output logic            sync_flag
);

    localparam int unsigned TOT_W = SS_W + TM_W + DT_W;

    logic [SS_W-1:0]  hold_ssr;
    logic [TM_W-1:0]  hold_tr;
    logic [DT_W-1:0]  hold_dr;
    logic             xfer_req;
    logic [SS_W-1:0]  shd_ssr;
    logic [TM_W-1:0]  shd_tr;
    logic [DT_W-1:0]  shd_dr;
    logic             cap_pulse;
    logic [TOT_W-1:0] live_bus;

    cal_xfer_launch #(
        .SS_W        (SS_W),
        .TM_W        (TM_W),
        .DT_W        (DT_W),
        .COPY_PERIOD (COPY_PERIOD)
    ) u_launch (
        .rtc_clk   (rtc_clk),
        .rtc_rst_n (rtc_rst_n),
        .live_ssr  (live_ssr),
        .live_tr   (live_tr),
        .live_dr   (live_dr),
        .lp_active (lp_active),
        .hold_ssr  (hold_ssr),
        .hold_tr   (hold_tr),
        .hold_dr   (hold_dr),
        .xfer_req  (xfer_req)
    );

    cal_xfer_capture #(
        .SS_W        (SS_W),
        .TM_W        (TM_W),
        .DT_W        (DT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_capture (
        .bus_clk    (bus_clk),
        .bus_rst_n  (bus_rst_n),
        .xfer_req   (xfer_req),
        .hold_ssr   (hold_ssr),
        .hold_tr    (hold_tr),
        .hold_dr    (hold_dr),
        .bypass_en  (bypass_en),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .shd_ssr    (shd_ssr),
        .shd_tr     (shd_tr),
        .shd_dr     (shd_dr),
        .sync_flag  (sync_flag),
        .cap_pulse  (cap_pulse)
    );

    cal_sync_ff #(
        .W      (TOT_W),
        .STAGES (SYNC_STAGES)
    ) u_live_sync (
        .clk   (bus_clk),
        .rst_n (bus_rst_n),
        .d     ({live_ssr, live_tr, live_dr}),
        .q     (live_bus)
    );

    // Purpose: read path picks the synchronized live words in bypass, else the shadows.
    always_comb begin
        if (bypass_en) begin
            rd_ssr = live_bus[TOT_W-1 -: SS_W];
            rd_tr  = live_bus[DT_W +: TM_W];
            rd_dr  = live_bus[0 +: DT_W];
        end else begin
            rd_ssr = shd_ssr;
            rd_tr  = shd_tr;
            rd_dr  = shd_dr;
        end
    end

endmodule

// File: rtl/cal_shadow_sync_chk.sv
// Module: assertion checker for cal_shadow_sync, attached by bind.
// Assumes it sees the request toggle and the capture pulse of the top.
module cal_shadow_sync_chk #(
    parameter int unsigned TOT_W = 64
) (
    input logic             rtc_clk,
    input logic             rtc_rst_n,
    input logic             lp_active,
    input logic             xfer_req,
    input logic             bus_clk,
    input logic             bus_rst_n,
    input logic             bypass_en,
    input logic             flag_wr,
    input logic             flag_wdata,
    input logic             cap_pulse,
    input logic             sync_flag,
    input logic [TOT_W-1:0] shd_all
);

    logic [2:0] gap_q;
    logic       req_prev_q;

    // Purpose: track RTC cycles since the last launch outside low power.
    always_ff @(posedge rtc_clk) begin
        if (!rtc_rst_n) begin
            gap_q      <= '0;
            req_prev_q <= 1'b0;
        end else begin
            req_prev_q <= xfer_req;
            if (lp_active || (xfer_req != req_prev_q)) gap_q <= '0;
            else if (gap_q != 3'd7)                    gap_q <= gap_q + 1'b1;
        end
    end

    assert_copy_spacing_R2: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
        !$stable(xfer_req) |=> $stable(xfer_req));

    assert_shadow_atomic_R3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !cap_pulse |=> $stable(shd_all));

    assert_flag_set_R4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (cap_pulse && !bypass_en) |=> sync_flag);

    assert_flag_clear_R5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (flag_wr && !flag_wdata && !(cap_pulse && !bypass_en)) |=> !sync_flag);

    assert_no_copy_lowpower_R6: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
        lp_active |=> $stable(xfer_req));

    assert_refresh_bound_R7: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
        gap_q < 3'd4);

    assert_flag_quiet_bypass_R8: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        bypass_en |=> !$rose(sync_flag));

endmodule

bind cal_shadow_sync cal_shadow_sync_chk #(
    .TOT_W (SS_W + TM_W + DT_W)
) u_chk (
    .rtc_clk    (rtc_clk),
    .rtc_rst_n  (rtc_rst_n),
    .lp_active  (lp_active),
    .xfer_req   (xfer_req),
    .bus_clk    (bus_clk),
    .bus_rst_n  (bus_rst_n),
    .bypass_en  (bypass_en),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .cap_pulse  (cap_pulse),
    .sync_flag  (sync_flag),
    .shd_all    ({shd_ssr, shd_tr, shd_dr})
);

// File: tb/test_cal_shadow_sync.sv
// Bench for cal_shadow_sync: directed corner cases plus seeded random
// rounds; all expected values come from the pattern function below.
module test_cal_shadow_sync;

    localparam int unsigned SS_W = 16;
    localparam int unsigned TM_W = 24;
    localparam int unsigned DT_W = 24;

    logic            rtc_clk = 1'b0;
    logic            bus_clk = 1'b0;
    logic            rtc_rst_n = 1'b0;
    logic            bus_rst_n = 1'b0;
    logic [SS_W-1:0] live_ssr = '0;
    logic [TM_W-1:0] live_tr = '0;
    logic [DT_W-1:0] live_dr = '0;
    logic            lp_active = 1'b0;
    logic            bypass_en = 1'b0;
    logic            flag_wr = 1'b0;
    logic            flag_wdata = 1'b0;
    logic [SS_W-1:0] rd_ssr;
    logic [TM_W-1:0] rd_tr;
    logic [DT_W-1:0] rd_dr;
    logic            sync_flag;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned n_torn = 0;
    logic [15:0] exp_shadow = '0;
    logic [15:0] seed_k;
    int unsigned dummy;

    always #2  bus_clk = ~bus_clk;   // 250 MHz
    always #20 rtc_clk = ~rtc_clk;

    cal_shadow_sync i_cal_shadow_sync (
        .rtc_clk    (rtc_clk),
        .rtc_rst_n  (rtc_rst_n),
        .live_ssr   (live_ssr),
        .live_tr    (live_tr),
        .live_dr    (live_dr),
        .lp_active  (lp_active),
        .bus_clk    (bus_clk),
        .bus_rst_n  (bus_rst_n),
        .bypass_en  (bypass_en),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .rd_ssr     (rd_ssr),
        .rd_tr      (rd_tr),
        .rd_dr      (rd_dr),
        .sync_flag  (sync_flag)
    );

    // All three fields are derived from one 16-bit seed.
    function automatic logic [63:0] pattern(input logic [15:0] k);
        return {k, k[7:0], k, k[15:8], k};
    endfunction

    function automatic bit coherent(input logic [63:0] v);
        logic [15:0] s;
        s = v[63:48];
        return (v[47:40] == s[7:0]) && (v[39:24] == s) &&
               (v[23:16] == s[15:8]) && (v[15:0] == s);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_live(input logic [15:0] k);
        @(negedge rtc_clk);
        {live_ssr, live_tr, live_dr} = pattern(k);
    endtask

    task automatic write_flag(input logic v);
        @(negedge bus_clk);
        flag_wr = 1'b1;
        flag_wdata = v;
        @(negedge bus_clk);
        flag_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge rtc_clk);
        repeat (6) @(negedge bus_clk);
    endtask

    function automatic logic [63:0] rd_all();
        return {rd_ssr, rd_tr, rd_dr};
    endfunction

    // R3 monitor: read outputs must always agree on one seed.
    always @(negedge bus_clk) begin
        if (bus_rst_n && !coherent({rd_ssr, rd_tr, rd_dr})) n_torn++;
    end

    initial begin
        repeat (150000) @(posedge bus_clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        dummy = $urandom(32'h5EED_0042);
        repeat (4) @(negedge rtc_clk);
        @(negedge bus_clk);
        check(rd_all() == 64'd0, "R1 reads zero in reset", rd_all(), 64'd0);
        check(sync_flag == 1'b0, "R1 flag zero in reset", 64'(sync_flag), 64'd0);
        @(negedge rtc_clk);
        rtc_rst_n = 1'b1;
        @(negedge bus_clk);
        bus_rst_n = 1'b1;
        @(negedge bus_clk);
        check(rd_all() == 64'd0 && sync_flag == 1'b0, "R1 zero after reset", {rd_all()[63:1], sync_flag}, 64'd0);

        // R2 / R4: first real copy
        set_live(16'h1234);
        settle();
        check(rd_all() == pattern(16'h1234), "R2 shadow follows live", rd_all(), pattern(16'h1234));
        check(sync_flag == 1'b1, "R4 flag set by copy", 64'(sync_flag), 64'd1);
        exp_shadow = 16'h1234;

        // R5 / R6: enter low power, drain, then exercise the flag
        @(negedge rtc_clk);
        lp_active = 1'b1;
        repeat (3) @(posedge rtc_clk);
        write_flag(1'b1);
        check(sync_flag == 1'b1, "R5 writing 1 ignored", 64'(sync_flag), 64'd1);
        write_flag(1'b0);
        check(sync_flag == 1'b0, "R5 writing 0 clears", 64'(sync_flag), 64'd0);
        set_live(16'hBEEF);
        repeat (6) @(posedge rtc_clk);
        @(negedge bus_clk);
        check(rd_all() == pattern(16'h1234), "R6 shadows frozen in low power", rd_all(), pattern(16'h1234));
        check(sync_flag == 1'b0, "R6 flag stays clear in low power", 64'(sync_flag), 64'd0);

        // R7: bounded refresh after exit
        @(negedge rtc_clk);
        lp_active = 1'b0;
        repeat (4) @(posedge rtc_clk);
        repeat (5) @(negedge bus_clk);
        check(rd_all() == pattern(16'hBEEF), "R7 refresh within bound", rd_all(), pattern(16'hBEEF));
        check(sync_flag == 1'b1, "R7 flag set after exit", 64'(sync_flag), 64'd1);

        // R8: bypass shows live values, flag untouched
        @(negedge bus_clk);
        bypass_en = 1'b1;
        write_flag(1'b0);
        set_live(16'h0F0F);
        repeat (4) @(negedge bus_clk);
        check(rd_all() == pattern(16'h0F0F), "R8 bypass reads live", rd_all(), pattern(16'h0F0F));
        repeat (6) @(posedge rtc_clk);
        @(negedge bus_clk);
        check(sync_flag == 1'b0, "R8 flag not set in bypass", 64'(sync_flag), 64'd0);
        @(negedge bus_clk);
        bypass_en = 1'b0;
        @(negedge bus_clk);
        check(rd_all() == pattern(16'h0F0F), "R8 shadows kept updating", rd_all(), pattern(16'h0F0F));
        exp_shadow = 16'h0F0F;

        // Random rounds over the three operating situations
        for (int i = 0; i < 40; i++) begin
            int unsigned mode;
            mode = $urandom % 3;
            seed_k = 16'($urandom);
            if (mode == 0) begin
                set_live(seed_k);
                settle();
                check(rd_all() == pattern(seed_k), "R2 random copy", rd_all(), pattern(seed_k));
                check(sync_flag == 1'b1, "R4 random flag", 64'(sync_flag), 64'd1);
                exp_shadow = seed_k;
            end else if (mode == 1) begin
                @(negedge bus_clk);
                bypass_en = 1'b1;
                write_flag(1'b0);
                set_live(seed_k);
                repeat ($urandom % 3) @(posedge rtc_clk);
                repeat (4) @(negedge bus_clk);
                check(rd_all() == pattern(seed_k), "R8 random bypass", rd_all(), pattern(seed_k));
                check(sync_flag == 1'b0, "R8 random flag quiet", 64'(sync_flag), 64'd0);
                settle();
                @(negedge bus_clk);
                bypass_en = 1'b0;
                exp_shadow = seed_k;
            end else begin
                @(negedge rtc_clk);
                lp_active = 1'b1;
                repeat (3) @(posedge rtc_clk);
                write_flag(1'b0);
                set_live(seed_k);
                repeat (2 + $urandom % 4) @(posedge rtc_clk);
                @(negedge bus_clk);
                check(rd_all() == pattern(exp_shadow), "R6 random low power hold", rd_all(), pattern(exp_shadow));
                check(sync_flag == 1'b0, "R6 random flag quiet", 64'(sync_flag), 64'd0);
                @(negedge rtc_clk);
                lp_active = 1'b0;
                repeat (4) @(posedge rtc_clk);
                repeat (5) @(negedge bus_clk);
                check(rd_all() == pattern(seed_k), "R7 random refresh", rd_all(), pattern(seed_k));
                exp_shadow = seed_k;
            end
        end

        check(n_torn == 0, "R3 no torn reads", 64'(n_torn), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule